// File: doc/BRIEF.md
# 1-Wire Slave ROM Command Layer

This block is the addressing stage of a 1-Wire slave. It sits between a link layer, which turns bus time slots into single-cycle bit strobes, and a function layer, which only takes part after the block grants it access. After the link layer reports a bus reset with presence, the block collects an 8-bit command, least significant bit first. Depending on that byte it sends out its 64-bit identity, compares one received from the master, runs the search triplet sequence, or grants access at once. A failed compare or an unknown command makes the block silent until the next bus reset.

The identity is fixed at elaboration. It is made of a family code in bits 7:0, a 48-bit serial number in bits 55:8 and a CRC-8 in bits 63:56. The CRC is computed by default from the other 56 bits with the polynomial x^8+x^5+x^4+1, starting from zero. Feeding all 64 bits through the same generator then leaves zero.

The named states and transitions are:
- `ST_QUIET` leads to `ST_CMD` on a bus reset.
- `ST_CMD` leads, after the eighth bit, to `ST_READ` (33h), `ST_MATCH` (55h), `ST_SRCH_TRUE` (F0h), `ST_GRANT` (CCh) or `ST_QUIET` (any other code).
- `ST_READ` leads to `ST_GRANT` after the 64th sent bit.
- `ST_MATCH` leads to `ST_GRANT` after 64 equal bits, or to `ST_QUIET` on the first bit that differs.
- `ST_SRCH_TRUE` leads to `ST_SRCH_CMPL`, then to `ST_SRCH_DIR`. From there it goes back to `ST_SRCH_TRUE` for the next bit, to `ST_GRANT` after bit 63, or to `ST_QUIET` when the bit differs.
- A bus reset in any state leads to `ST_CMD`.

Top module: `owrom_layer`

## Requirements
- R1: After power-on reset, the block stays silent until the first bus reset strobe. `grant_o` is 0 and `tx_bit_o` is 1, and a complete skip command (CCh) sent before that strobe grants nothing.
- R2: A bus reset strobe in any state drops `grant_o` in the following cycle and restarts command reception from bit 0.
- R3: The command byte is taken from eight received bits, least significant bit first. The codes are 33h read, 55h match, F0h search and CCh skip.
- R4: Read presents identity bit k on `tx_bit_o` for the k-th send request, for k from 0 to 63: family code LSB first, then the serial number, then the CRC byte. `grant_o` rises after the 64th request and not before.
- R5: Match compares each received bit with identity bit k. After 64 equal bits, `grant_o` rises. The first bit that differs makes the block silent, with no grant and `tx_bit_o` at 1, until a bus reset.
- R6: For each bit k, search sends identity bit k, then its complement, then takes the master's bit. If the master's bit equals bit k, the block moves on, and it grants after bit 63. If it differs, the block goes silent until a bus reset.
- R7: Skip (CCh) raises `grant_o` in the cycle after the eighth command bit, with no identity exchange.
- R8: Any other command byte makes the block silent. Later received bits and send requests cause no grant, and `tx_bit_o` stays 1, until a bus reset.
- R9: With default parameters the family code is 24h, and the 64 identity bits, fed LSB first through x^8+x^5+x^4+1 from zero, leave a zero residue.
- R10: Once granted, `grant_o` stays 1 whatever bits or requests arrive, until a bus reset strobe.
- R11: `tx_bit_o` is 1 (line released) in every state except those that send an identity bit or its complement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| bus_reset_i | input | 1 | One-cycle strobe: the link layer saw a bus reset and sent presence |
| rx_valid_i | input | 1 | One-cycle strobe: the master wrote a bit |
| rx_bit_i | input | 1 | Value of the bit the master wrote, valid with `rx_valid_i` |
| tx_req_i | input | 1 | One-cycle strobe: the master opened a read slot; consumes `tx_bit_o` |
| tx_bit_o | output | 1 | Bit to drive in the current read slot; 1 means release the line |
| grant_o | output | 1 | Function layer may now take over the bus |

## Verification
The hardest situations to reach are the search drop-out and the match failure far into the identity. Both need dozens of correctly ordered strobes before the one bit that matters. The bench drives the full triplet sequence from its own copy of the identity and flips exactly one chosen bit (bit 5 in search, bit 40 in match). It then keeps issuing the remaining strobes to show that the block stays silent and never grants. A bus reset in the middle of a read and a skip sent before any bus reset are reached the same way, with directed strobe sequences.

// File: rtl/owrom_pkg.sv
package owrom_pkg;

    localparam int FAM_W = 8;
    localparam int SER_W = 48;
    localparam int CRC_W = 8;
    localparam int ID_W  = FAM_W + SER_W + CRC_W;
    localparam int CMD_W = 8;

    localparam logic [CMD_W-1:0] CMD_READ   = 8'h33;
    localparam logic [CMD_W-1:0] CMD_MATCH  = 8'h55;
    localparam logic [CMD_W-1:0] CMD_SEARCH = 8'hF0;
    localparam logic [CMD_W-1:0] CMD_SKIP   = 8'hCC;

    typedef enum logic [2:0] {
        ST_QUIET,
        ST_CMD,
        ST_READ,
        ST_MATCH,
        ST_SRCH_TRUE,
        ST_SRCH_CMPL,
        ST_SRCH_DIR,
        ST_GRANT
    } rom_state_e;

    // Elaboration-time CRC-8 (x^8+x^5+x^4+1), data entered LSB first.
    function automatic logic [CRC_W-1:0] crc8_over(input logic [FAM_W+SER_W-1:0] data);
        logic [CRC_W-1:0] r;
        logic             fb;
        r = '0;
        for (int i = 0; i < FAM_W + SER_W; i++) begin
            fb   = r[0] ^ data[i];
            r    = {fb, r[7:1]};
            r[3] = r[3] ^ fb;
            r[2] = r[2] ^ fb;
        end
        return r;
    endfunction

endpackage

// File: rtl/owrom_cmd_shift.sv
module owrom_cmd_shift #(
    parameter int CMD_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             shift_en,
    input  logic             bit_in,
    output logic [CMD_W-1:0] cmd_full,
    output logic             last
);
    localparam int CNT_W = (CMD_W > 1) ? $clog2(CMD_W) : 1;

    logic [CMD_W-1:0] sh_q;
    logic [CNT_W-1:0] cnt_q;

    // Bits arrive LSB first: each new bit enters at the top.
    assign cmd_full = {bit_in, sh_q[CMD_W-1:1]};
    assign last     = (cnt_q == CNT_W'(CMD_W - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (clear) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (shift_en) begin
            sh_q  <= cmd_full;
            cnt_q <= last ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/owrom_id_cursor.sv
module owrom_id_cursor #(
    parameter int ID_W = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            step,
    input  logic [ID_W-1:0] identity,
    output logic            cur_bit,
    output logic            last
);
    localparam int IDX_W = $clog2(ID_W);

    logic [IDX_W-1:0] idx_q;

    assign cur_bit = identity[idx_q];
    assign last    = (idx_q == IDX_W'(ID_W - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (clear) begin
            idx_q <= '0;
        end else if (step) begin
            idx_q <= idx_q + 1'b1;
        end
    end
endmodule

// File: rtl/owrom_layer.sv
module owrom_layer #(
    parameter logic [owrom_pkg::FAM_W-1:0] FAMILY_CODE = 8'h24,
    parameter logic [owrom_pkg::SER_W-1:0] SERIAL_NUM  = 48'h00A1_B2C3_D4E5,
    parameter logic [owrom_pkg::CRC_W-1:0] ID_CRC      =
        owrom_pkg::crc8_over({SERIAL_NUM, FAMILY_CODE})
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_reset_i,
    input  logic rx_valid_i,
    input  logic rx_bit_i,
    input  logic tx_req_i,
    output logic tx_bit_o,
    output logic grant_o
);
    import owrom_pkg::*;

    localparam logic [ID_W-1:0] IDENTITY = {ID_CRC, SERIAL_NUM, FAMILY_CODE};

    rom_state_e       state_q, state_d;
    logic             cmd_clear, cmd_shift_en, cmd_last;
    logic [CMD_W-1:0] cmd_full;
    logic             idx_clear, idx_step, id_bit, id_last;

    owrom_cmd_shift #(.CMD_W(CMD_W)) cmd_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (cmd_clear),
        .shift_en (cmd_shift_en),
        .bit_in   (rx_bit_i),
        .cmd_full (cmd_full),
        .last     (cmd_last)
    );

    owrom_id_cursor #(.ID_W(ID_W)) cur_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (idx_clear),
        .step     (idx_step),
        .identity (IDENTITY),
        .cur_bit  (id_bit),
        .last     (id_last)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and datapath controls
    always_comb begin
        state_d      = state_q;
        cmd_clear    = 1'b0;
        cmd_shift_en = 1'b0;
        idx_clear    = 1'b0;
        idx_step     = 1'b0;
        if (bus_reset_i) begin
            state_d   = ST_CMD;
            cmd_clear = 1'b1;
            idx_clear = 1'b1;
        end else begin
            unique case (state_q)
                ST_QUIET: begin
                    state_d = ST_QUIET;
                end
                ST_CMD: begin
                    if (rx_valid_i) begin
                        cmd_shift_en = 1'b1;
                        if (cmd_last) begin
                            idx_clear = 1'b1;
                            case (cmd_full)
                                CMD_READ:   state_d = ST_READ;
                                CMD_MATCH:  state_d = ST_MATCH;
                                CMD_SEARCH: state_d = ST_SRCH_TRUE;
                                CMD_SKIP:   state_d = ST_GRANT;
                                default:    state_d = ST_QUIET;
                            endcase
                        end
                    end
                end
                ST_READ: begin
                    if (tx_req_i) begin
                        if (id_last) state_d  = ST_GRANT;
                        else         idx_step = 1'b1;
                    end
                end
                ST_MATCH: begin
                    if (rx_valid_i) begin
                        if (rx_bit_i != id_bit) state_d  = ST_QUIET;
                        else if (id_last)       state_d  = ST_GRANT;
                        else                    idx_step = 1'b1;
                    end
                end
                ST_SRCH_TRUE: begin
                    if (tx_req_i) state_d = ST_SRCH_CMPL;
                end
                ST_SRCH_CMPL: begin
                    if (tx_req_i) state_d = ST_SRCH_DIR;
                end
                ST_SRCH_DIR: begin
                    if (rx_valid_i) begin
                        if (rx_bit_i != id_bit) begin
                            state_d = ST_QUIET;
                        end else if (id_last) begin
                            state_d = ST_GRANT;
                        end else begin
                            idx_step = 1'b1;
                            state_d  = ST_SRCH_TRUE;
                        end
                    end
                end
                ST_GRANT: begin
                    state_d = ST_GRANT;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        grant_o  = 1'b0;
        tx_bit_o = 1'b1;
        unique case (state_q)
            ST_READ,
            ST_SRCH_TRUE: tx_bit_o = id_bit;
            ST_SRCH_CMPL: tx_bit_o = ~id_bit;
            ST_GRANT:     grant_o  = 1'b1;
            ST_QUIET, ST_CMD, ST_MATCH, ST_SRCH_DIR: begin
                tx_bit_o = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/owrom_layer_chk.sv
module owrom_layer_chk (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_reset_i,
    input logic                  tx_bit_o,
    input logic                  grant_o,
    input owrom_pkg::rom_state_e state_q
);
    import owrom_pkg::*;

    logic seen_bus_reset_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           seen_bus_reset_q <= 1'b0;
        else if (bus_reset_i) seen_bus_reset_q <= 1'b1;
    end

    // R1
    no_grant_before_bus_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_bus_reset_q |-> (!grant_o && tx_bit_o));

    // R2
    bus_reset_drops_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset_i |=> (!grant_o && state_q == ST_CMD));

    // R10
    grant_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o && !bus_reset_i) |=> grant_o);

    // R11
    line_released_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_QUIET || state_q == ST_GRANT || state_q == ST_CMD) |-> tx_bit_o);

    // R6
    search_complement_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SRCH_CMPL && $past(state_q) == ST_SRCH_TRUE) |-> (tx_bit_o != $past(tx_bit_o)));

    // R8
    quiet_stays_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_QUIET && !bus_reset_i) |=> (!grant_o && state_q == ST_QUIET));
endmodule

bind owrom_layer owrom_layer_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_reset_i (bus_reset_i),
    .tx_bit_o    (tx_bit_o),
    .grant_o     (grant_o),
    .state_q     (state_q)
);

// File: tb/owrom_layer_tb.sv
module owrom_layer_tb_top;

    localparam logic [7:0]  FAM = 8'h24;
    localparam logic [47:0] SER = 48'h00A1_B2C3_D4E5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_reset_i = 1'b0;
    logic rx_valid_i = 1'b0;
    logic rx_bit_i = 1'b0;
    logic tx_req_i = 1'b0;
    logic tx_bit_o, grant_o;

    int checks = 0;
    int errors = 0;
    logic [63:0] exp_id;

    always #10 clk = ~clk;

    owrom_layer dut_i (
        .clk(clk), .rst_n(rst_n), .bus_reset_i(bus_reset_i),
        .rx_valid_i(rx_valid_i), .rx_bit_i(rx_bit_i), .tx_req_i(tx_req_i),
        .tx_bit_o(tx_bit_o), .grant_o(grant_o)
    );

    // Bench-side CRC: reflected form of x^8+x^5+x^4+1.
    function automatic logic [7:0] tb_crc(input logic [7:0] c, input logic b);
        logic [7:0] n;
        n = c >> 1;
        if (c[0] ^ b) n = n ^ 8'h8C;
        return n;
    endfunction

    task automatic chk(input logic [63:0] act, input logic [63:0] expv, input string req);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic bus_reset();
        @(negedge clk); bus_reset_i = 1'b1;
        @(negedge clk); bus_reset_i = 1'b0;
    endtask

    task automatic put_bit(input logic b);
        @(negedge clk); rx_valid_i = 1'b1; rx_bit_i = b;
        @(negedge clk); rx_valid_i = 1'b0;
    endtask

    task automatic put_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) put_bit(v[i]);
    endtask

    task automatic get_bit(output logic b);
        @(negedge clk); b = tx_bit_o; tx_req_i = 1'b1;
        @(negedge clk); tx_req_i = 1'b0;
    endtask

    task automatic t_power_on();
        chk(grant_o, 1'b0, "R1 grant after power-on");
        chk(tx_bit_o, 1'b1, "R1 line released after power-on");
        put_byte(8'hCC);
        chk(grant_o, 1'b0, "R1 skip before bus reset ignored");
    endtask

    task automatic t_skip();
        logic b;
        bus_reset();
        put_byte(8'hCC);
        chk(grant_o, 1'b1, "R7 R3 skip grants");
        put_byte(8'h33);
        get_bit(b);
        chk(b, 1'b1, "R11 released while granted");
        chk(grant_o, 1'b1, "R10 grant held through strobes");
        bus_reset();
        chk(grant_o, 1'b0, "R2 bus reset drops grant");
    endtask

    task automatic t_read();
        logic b;
        logic [7:0] res = 8'h00;
        logic [63:0] got = '0;
        bus_reset();
        put_byte(8'h33);
        for (int k = 0; k < 64; k++) begin
            if (k == 63) chk(grant_o, 1'b0, "R4 no grant before last bit");
            get_bit(b);
            got[k] = b;
            res = tb_crc(res, b);
        end
        chk(got, exp_id, "R4 identity read order");
        chk(grant_o, 1'b1, "R4 grant after read");
        chk(got[7:0], 8'h24, "R9 family code");
        chk(res, 8'h00, "R9 crc residue");
    endtask

    task automatic t_match(input int bad_k);
        bus_reset();
        put_byte(8'h55);
        for (int k = 0; k < 64; k++) put_bit((k == bad_k) ? ~exp_id[k] : exp_id[k]);
        if (bad_k < 0) begin
            chk(grant_o, 1'b1, "R5 match grants");
        end else begin
            logic b;
            chk(grant_o, 1'b0, "R5 mismatch no grant");
            get_bit(b);
            chk(b, 1'b1, "R5 silent after mismatch");
        end
    endtask

    task automatic t_search(input int bad_k);
        logic a, c;
        int bad_pairs = 0;
        int released = 0;
        bus_reset();
        put_byte(8'hF0);
        for (int k = 0; k < 64; k++) begin
            get_bit(a);
            get_bit(c);
            if (bad_k < 0 || k <= bad_k) begin
                if (a !== exp_id[k] || c !== ~exp_id[k]) bad_pairs++;
            end else if (a === 1'b1 && c === 1'b1) begin
                released++;
            end
            put_bit((k == bad_k) ? ~exp_id[k] : exp_id[k]);
        end
        chk(bad_pairs, 0, "R6 true/complement pairs");
        if (bad_k < 0) begin
            chk(grant_o, 1'b1, "R6 search grants");
        end else begin
            chk(released, 63 - bad_k, "R6 silent after drop-out");
            chk(grant_o, 1'b0, "R6 no grant after drop-out");
        end
    endtask

    task automatic t_unknown();
        logic b;
        bus_reset();
        put_byte(8'hA5);
        chk(grant_o, 1'b0, "R8 unknown code no grant");
        put_byte(8'hCC);
        get_bit(b);
        chk(b, 1'b1, "R8 released after unknown code");
        chk(grant_o, 1'b0, "R8 later skip ignored");
        bus_reset();
        put_byte(8'hCC);
        chk(grant_o, 1'b1, "R2 recovery after bus reset");
    endtask

    task automatic t_reset_mid();
        logic b;
        bus_reset();
        put_byte(8'h33);
        for (int k = 0; k < 20; k++) get_bit(b);
        bus_reset();
        put_byte(8'h33);
        get_bit(b);
        chk(b, exp_id[0], "R2 read restarts at bit 0");
        bus_reset();
        put_byte(8'hCC);
        chk(grant_o, 1'b1, "R2 command restart after mid-read reset");
    endtask

    initial begin
        logic [7:0] c = 8'h00;
        logic [55:0] body = {SER, FAM};
        for (int i = 0; i < 56; i++) c = tb_crc(c, body[i]);
        exp_id = {c, SER, FAM};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_power_on();
        t_skip();
        t_read();
        t_match(-1);
        t_match(40);
        t_search(-1);
        t_search(5);
        t_unknown();
        t_reset_mid();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #4000000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule